// File: doc/BRIEF.md
# Reset Cause and Low-Speed Oscillator Control Register

This block is one 32-bit control and status word. Its main job is to remember which reset sources have fired since software last looked. Six reset-event inputs each own one sticky flag. The hardware sets that flag, and only a deliberate software write clears it. That write goes to a trigger bit that clears all six flags together and never holds a value of its own. The flags live in the power domain, so a power-on reset is the only thing that returns them to their initial state. Every other reset just adds its own flag.

The same word also controls a low-speed internal oscillator. Software sets or clears an enable bit, and that bit drives the oscillator enable pin. The oscillator's stable indication comes back through a synchronizer and appears as a read-only ready bit. The ready bit is gated so that it reads 0 while the oscillator is disabled.

Access is through a single-cycle port. A write strobe with write data updates the register at the next clock edge. The read data is the current contents and is always available. The event inputs are one-cycle pulses that are already in the register's clock domain.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit 0 is the oscillator enable. A write stores `wdata[0]` at the clock edge. The stored value reads back on `rdata[0]` and drives `osc_en_o`, and it holds until the next write.
- R2: Bit 1 shows `osc_rdy_i` after a synchronizer of `SYNC_STAGES` flops (default 2). With the enable set, a rise of `osc_rdy_i` shows on `rdata[1]` after the second clock edge and not after the first.
- R3: `rdata[1]` reads 0 in any cycle where the enable bit is 0, whatever the state of `osc_rdy_i`.
- R4: Bits 23:2 and bit 31 always read 0. Writing 1 to bit 1, to bits 23:2, or to bits 31:25 changes no readable bit.
- R5: Writing 1 to bit 24 clears all six reset-cause flags at that clock edge. Bit 24 itself always reads 0.
- R6: Flag bits 25 to 30 record brownout, pin, power-on/power-down, software, independent watchdog and window watchdog resets. These map to `evt_i[0]` through `evt_i[5]`. A one-cycle pulse on `evt_i[k]` sets bit 25+k at that clock edge.
- R7: A flag that is set stays set through any number of cycles and events, and through writes that do not set bit 24.
- R8: A flag whose event pulses in the same cycle as a flag-clear write ends up set. The other flags are cleared by that write.
- R9: While `por_n` is low, the register holds enable = 0 and flags = only bit 27 (power-on/power-down). After release it reads `32'h0800_0000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| evt_i | input | 6 | Reset-event pulses, synchronous, one bit per source |
| osc_rdy_i | input | 1 | Oscillator stable indication, asynchronous |
| osc_en_o | output | 1 | Oscillator enable |
| rdata | output | 32 | Current register contents |

## Verification
The collision that matters is a reset event and a flag-clear write landing on the same clock edge. In that case the two updates to one flag disagree. The bench sets several flags and then issues a clear write in the same cycle as a software-reset pulse. It judges the result on the next read: bit 28 must be set and every other flag bit must be 0. A second, overlapping case writes the enable to 0 while the oscillator reports stable, and checks that the ready bit drops in the same cycle.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
   // Field positions fixed by the register layout
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned RDY_BIT  = 1;
   localparam int unsigned CLR_BIT  = 24;
   localparam int unsigned FLAG_LSB = 25;
   localparam int unsigned NUM_SRC  = 6;

   // Source index within the flag field (bit = FLAG_LSB + index)
   typedef enum int unsigned {
      SRC_BROWNOUT = 0,
      SRC_PIN      = 1,
      SRC_PWR      = 2,
      SRC_SOFT     = 3,
      SRC_IND_WDG  = 4,
      SRC_WIN_WDG  = 5
   } src_idx_e;

   localparam int unsigned PWR_IDX = SRC_PWR;
endpackage

// File: rtl/rcsr_sync.sv
module rcsr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcsr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcsr_flags.sv
module rcsr_flags #(
   parameter int unsigned NSRC    = 6,
   parameter int unsigned INIT_IX = 2
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            clr_i,
   input  logic [NSRC-1:0] evt_i,
   output logic [NSRC-1:0] flag_o
);
   generate
      if (INIT_IX >= NSRC) begin : g_bad_init
         $error("rcsr_flags: INIT_IX out of range");
      end
   endgenerate

   logic [NSRC-1:0] flag_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_flag
         localparam logic INIT_V = (i == INIT_IX);
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) flag_q[i] <= INIT_V;
            else        flag_q[i] <= evt_i[i] | (flag_q[i] & ~clr_i);
         end
      end
   endgenerate

   assign flag_o = flag_q;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rcsr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               osc_rdy_i,
   output logic               osc_en_o,
   output logic [DATA_W-1:0]  rdata
);
   localparam int unsigned FLAG_MSB = FLAG_LSB + NUM_SRC - 1;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("rst_cause_reg: DATA_W must be 32 for this layout");
      end
      if (FLAG_MSB >= DATA_W) begin : g_bad_field
         $error("rst_cause_reg: flag field exceeds data width");
      end
   endgenerate

   logic               en_q;
   logic               rdy_sync;
   logic               clr_req;
   logic [NUM_SRC-1:0] flags;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     en_q <= 1'b0;
      else if (wr_en) en_q <= wdata[EN_BIT];
   end

   assign clr_req = wr_en & wdata[CLR_BIT];

   rcsr_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d_i   (osc_rdy_i),
      .q_o   (rdy_sync)
   );

   rcsr_flags #(.NSRC(NUM_SRC), .INIT_IX(PWR_IDX)) u_flags (
      .clk    (clk),
      .por_n  (por_n),
      .clr_i  (clr_req),
      .evt_i  (evt_i),
      .flag_o (flags)
   );

   always_comb begin
      rdata                           = '0;
      rdata[EN_BIT]                   = en_q;
      rdata[RDY_BIT]                  = rdy_sync & en_q;
      rdata[FLAG_MSB:FLAG_LSB]        = flags;
   end

   assign osc_en_o = en_q;

   logic unused_wdata;
   assign unused_wdata = ^{wdata[DATA_W-1:CLR_BIT+1], wdata[CLR_BIT-1:EN_BIT+1]};
endmodule

// File: rtl/rcsr_chk.sv
module rcsr_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              por_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic [5:0]        evt_i,
   input logic              osc_en_o,
   input logic [DATA_W-1:0] rdata
);
   // R1
   en_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> (osc_en_o == $past(wdata[0])) && (rdata[0] == osc_en_o));

   // R1
   en_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(osc_en_o));

   // R3
   rdy_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      !osc_en_o |-> !rdata[1]);

   // R4
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rdata[23:2] == '0) && !rdata[31]);

   // R5
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rdata[24]);

   // R5
   clr_all_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wdata[24] && evt_i == '0) |=> (rdata[30:25] == '0));

   // R6
   evt_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (evt_i != '0) |=> ((rdata[30:25] & $past(evt_i)) == $past(evt_i)));

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(wr_en && wdata[24]) |=> ((rdata[30:25] & $past(rdata[30:25])) == $past(rdata[30:25])));
endmodule

bind rst_cause_reg rcsr_chk #(.DATA_W(DATA_W)) u_rcsr_chk (
   .clk      (clk),
   .por_n    (por_n),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .evt_i    (evt_i),
   .osc_en_o (osc_en_o),
   .rdata    (rdata)
);

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [5:0]  evt_i = '0;
   logic        osc_rdy_i = 1'b0;
   logic        osc_en_o;
   logic [31:0] rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_reg dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .evt_i     (evt_i),
      .osc_rdy_i (osc_rdy_i),
      .osc_en_o  (osc_en_o),
      .rdata     (rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic pulse(input logic [5:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R9 reset value", rdata, 32'h0800_0000);
      chk("R9 enable low", {31'b0, osc_en_o}, 32'h0);
   endtask

   task automatic t_enable();
      wr(32'h0000_0001);
      chk("R1 enable set", rdata, 32'h0800_0001);
      chk("R1 pin high", {31'b0, osc_en_o}, 32'h1);
      repeat (3) @(negedge clk);
      chk("R1 enable holds", {31'b0, osc_en_o}, 32'h1);
      wr(32'h0000_0000);
      chk("R1 enable clear", rdata, 32'h0800_0000);
   endtask

   task automatic t_ready();
      wr(32'h0000_0001);
      osc_rdy_i = 1'b1;
      @(negedge clk);
      chk("R2 one edge", {31'b0, rdata[1]}, 32'h0);
      @(negedge clk);
      chk("R2 two edges", {31'b0, rdata[1]}, 32'h1);
      @(negedge clk);
      wr_en = 1'b1; wdata = 32'h0;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R3 ready gated by enable", rdata, 32'h0800_0000);
      osc_rdy_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reserved();
      wr(32'hFEFF_FFFE);
      chk("R4 ro/reserved write no effect", rdata, 32'h0800_0000);
      wr(32'hFEFF_FFFF);
      chk("R4 reserved with enable", rdata, 32'h0800_0001);
      wr(32'h0000_0000);
   endtask

   task automatic t_clear();
      wr(32'h0100_0000);
      chk("R5 clear all flags", rdata, 32'h0000_0000);
   endtask

   task automatic t_events();
      logic [31:0] exp = 32'h0;
      for (int k = 0; k < 6; k++) begin
         pulse(6'(1 << k));
         exp[25+k] = 1'b1;
         chk("R6 event sets its flag", rdata, exp);
      end
      repeat (5) @(negedge clk);
      wr(32'h0000_0000);
      chk("R7 flags sticky", rdata, 32'h7E00_0000);
      pulse(6'b000001);
      chk("R7 repeat event keeps all", rdata, 32'h7E00_0000);
   endtask

   task automatic t_collide();
      @(negedge clk);
      wr_en = 1'b1; wdata = 32'h0100_0000; evt_i = 6'b001000;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; evt_i = '0;
      chk("R8 event beats clear", rdata, 32'h1000_0000);
   endtask

   task automatic t_por_mid();
      wr(32'h0000_0001);
      pulse(6'b110001);
      do_por();
      chk("R9 power reset restores", rdata, 32'h0800_0000);
      chk("R9 power reset enable", {31'b0, osc_en_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_ready();
      t_reserved();
      t_clear();
      t_events();
      t_collide();
      t_por_mid();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule